// File: doc/BRIEF.md
# BCD Countdown Timer Register

This block is a countdown timer that keeps hours, minutes and seconds as packed BCD and is driven only through writes to a single 32-bit register. When its run flag is set, the timer moves one second down on each pulse of a one-second tick input. When it reaches zero it stops, raises a sticky trigger flag and drives a one-cycle interrupt pulse. It also keeps the last nonzero start value, so a later command can reload that value.

The value written decides what a write does, and the timer state also matters. An all-zero write pauses a running timer. A write of the run flag alone resumes a paused one. An all-zero write to a timer stopped at zero reloads the saved start value. Any other write loads a new time. Every write clears the trigger flag. Bus address decode and the one-second tick source are outside the block. The block receives a write strobe with data and presents its read value at all times.

Control is a three-state machine. ST_STOPPED means the timer holds its time and ignores ticks. ST_RUNNING means the timer counts down on ticks. ST_EXPIRED means the timer is stopped at zero with the trigger set. The transitions are named as follows:
- START: a load or resume with a nonzero time, from a stopped state to ST_RUNNING.
- PAUSE: an all-zero write, from ST_RUNNING to ST_STOPPED.
- RELOAD: an all-zero write at zero time, which stays in or moves to ST_STOPPED.
- EXPIRE: a tick that reaches zero, from ST_RUNNING to ST_EXPIRED.
- CLEAR: any write in ST_EXPIRED, which leaves it.
- LOAD_STOPPED: a load without the run flag, or a load of a zero time, into ST_STOPPED.

Top module: `bcd_countdown_timer`

## Requirements
- R1: The read value is {6'b0, trigger, run, hours[7:0], minutes[7:0], seconds[7:0]}: seconds in bits 7:0, minutes in 15:8, hours in 23:16, run in bit 24, trigger in bit 25, and bits 31:26 always zero. After reset the read value is 0 and the interrupt is low.
- R2: A write whose bits 25:0 are neither 0 nor 26'h1000000 is a load. It sets the time to bits 23:0 in the next cycle and starts counting when bit 24 is set and the time is nonzero. While the timer runs, each tick lowers the time by one second.
- R3: The count is a BCD decrement. Seconds 00 borrows from minutes and becomes 59. Minutes 00 borrows from hours and becomes 59.
- R4: A write with bits 25:0 all zero while the timer runs stops it, and the remaining time is kept.
- R5: A write with bits 25:0 equal to 26'h1000000 resumes a stopped timer from its remaining time. If the remaining time is zero, the timer stays stopped. While the timer runs, this write has no effect.
- R6: The tick that brings a running timer to zero clears run, sets trigger and raises the interrupt for exactly one clock. The interrupt is visible in the same cycle as the zero time.
- R7: Any write clears the trigger bit.
- R8: A write with bits 25:0 all zero while the timer is stopped at zero reloads the last nonzero time that a load wrote, and the timer stays stopped.
- R9: Ticks have no effect while the timer is stopped. An all-zero write to a stopped timer holding a nonzero time has no effect.
- R10: When a write and a tick arrive in the same cycle, the write takes effect and the tick is dropped.
- R11: Write bits 31:26 are ignored. A load of a zero time never starts the timer and does not change the saved start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second tick pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | One-cycle interrupt on expiry |

## Verification
The decrement is tried in three cases:
- short second counts, where only the low digit changes;
- a 1:00 value, which forces a minute borrow;
- a 1:00:00 value, which forces a chained hour borrow. This separates a correct borrow from one that wraps to 99 or skips a field.

Writes are applied in each state with each of the three command kinds (zero, run-only, load). This tells apart the pause, resume, reload and no-op meanings that share one encoding. A write in the same cycle as a tick, and a load of zero with the run flag set, separate write priority and the zero-load rule from a plain load.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;
    localparam int FIELD_W  = 8;
    localparam int NFIELDS  = 3;
    localparam int TIME_W   = FIELD_W * NFIELDS;
    localparam int REG_W    = 32;
    localparam int RUN_BIT  = TIME_W;
    localparam int TRIG_BIT = TIME_W + 1;
    localparam int CMD_W    = TIME_W + 2;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_ZERO   = 2'd1,
        CMD_RESUME = 2'd2,
        CMD_LOAD   = 2'd3
    } tmr_cmd_e;
endpackage

// File: rtl/bcd_field_dec.sv
module bcd_field_dec #(
    parameter int TENS_MAX = 5
) (
    input  logic [7:0] val_i,
    input  logic       borrow_i,
    output logic [7:0] val_o,
    output logic       borrow_o
);
    logic [3:0] lo;
    logic [3:0] hi;

    assign lo = val_i[3:0];
    assign hi = val_i[7:4];

    always_comb begin
        val_o    = val_i;
        borrow_o = 1'b0;
        if (borrow_i) begin
            if (lo != 4'd0) begin
                val_o = {hi, lo - 4'd1};
            end else if (hi != 4'd0) begin
                val_o = {hi - 4'd1, 4'd9};
            end else begin
                val_o    = {4'(TENS_MAX), 4'd9};
                borrow_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_time_dec.sv
module bcd_time_dec
    import bcd_timer_pkg::*;
(
    input  logic [TIME_W-1:0] time_i,
    output logic [TIME_W-1:0] time_o
);
    logic [NFIELDS:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        localparam int TMAX = (g == NFIELDS - 1) ? 9 : 5;
        bcd_field_dec #(.TENS_MAX(TMAX)) u_field (
            .val_i   (time_i[g*FIELD_W +: FIELD_W]),
            .borrow_i(borrow[g]),
            .val_o   (time_o[g*FIELD_W +: FIELD_W]),
            .borrow_o(borrow[g+1])
        );
    end
endmodule

// File: rtl/bcd_timer_cmd.sv
module bcd_timer_cmd
    import bcd_timer_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output tmr_cmd_e         cmd
);
    logic [CMD_W-1:0] body;
    localparam logic [CMD_W-1:0] RESUME_CODE = CMD_W'(1) << RUN_BIT;

    assign body = wr_data[CMD_W-1:0];

    always_comb begin
        if (!wr_en)                   cmd = CMD_NONE;
        else if (body == '0)          cmd = CMD_ZERO;
        else if (body == RESUME_CODE) cmd = CMD_RESUME;
        else                          cmd = CMD_LOAD;
    end
endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer
    import bcd_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    tmr_state_e        state_q, state_n;
    tmr_cmd_e          cmd;
    logic [TIME_W-1:0] time_q, time_n;
    logic [TIME_W-1:0] start_q, start_n;
    logic [TIME_W-1:0] time_dec;
    logic [TIME_W-1:0] wr_time;
    logic              fire;
    logic              irq_q;

    assign wr_time = wr_data[TIME_W-1:0];

    bcd_timer_cmd u_cmd (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    bcd_time_dec u_dec (
        .time_i(time_q),
        .time_o(time_dec)
    );

    always_comb begin
        state_n = state_q;
        time_n  = time_q;
        start_n = start_q;
        fire    = 1'b0;
        if (cmd == CMD_LOAD) begin
            time_n = wr_time;
            if (wr_time != '0) start_n = wr_time;
            state_n = (wr_data[RUN_BIT] && wr_time != '0) ? ST_RUNNING : ST_STOPPED;
        end else begin
            unique case (state_q)
                ST_STOPPED, ST_EXPIRED: begin
                    if (cmd == CMD_ZERO) begin
                        if (time_q == '0) time_n = start_q;
                        state_n = ST_STOPPED;
                    end else if (cmd == CMD_RESUME) begin
                        state_n = (time_q != '0) ? ST_RUNNING : ST_STOPPED;
                    end
                end
                ST_RUNNING: begin
                    if (cmd == CMD_ZERO) begin
                        state_n = ST_STOPPED;
                    end else if (cmd == CMD_NONE && tick) begin
                        time_n = time_dec;
                        if (time_dec == '0) begin
                            state_n = ST_EXPIRED;
                            fire    = 1'b1;
                        end
                    end
                end
                default: state_n = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            time_q  <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_n;
            time_q  <= time_n;
            start_q <= start_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign irq     = irq_q;
    assign rd_data = {{(REG_W-CMD_W){1'b0}},
                      state_q == ST_EXPIRED,
                      state_q == ST_RUNNING,
                      time_q};
endmodule

// File: rtl/bcd_timer_checker.sv
module bcd_timer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        irq
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:26] == 6'd0);

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[25] && !rd_data[24] && rd_data[23:0] == 24'd0));

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_data[25]);

    assert_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:0] == 26'd0 && rd_data[24])
        |=> (!rd_data[24] && $stable(rd_data[23:0])));

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_data[24]) |=> $stable(rd_data[24:0]));

    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick && rd_data[24]) |=> $stable(rd_data[24:0]));

    assert_run_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[24] |-> (rd_data[23:0] != 24'd0));
endmodule

bind bcd_countdown_timer bcd_timer_checker u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .irq    (irq)
);

// File: tb/bcd_countdown_timer_bench.sv
module bcd_countdown_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_countdown_timer u_bcd_countdown_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // {we, tick, wdata, expected read, expected irq}
    localparam int NV = 22;
    localparam logic [66:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 32'h01000003, 32'h01000003, 1'b0}, // R2 load+run
        {1'b0, 1'b1, 32'h0,        32'h01000002, 1'b0}, // R2 tick
        {1'b0, 1'b0, 32'h0,        32'h01000002, 1'b0}, // R2 no tick
        {1'b0, 1'b1, 32'h0,        32'h01000001, 1'b0}, // R2
        {1'b0, 1'b1, 32'h0,        32'h02000000, 1'b1}, // R6 expire
        {1'b0, 1'b0, 32'h0,        32'h02000000, 1'b0}, // R6 single pulse
        {1'b0, 1'b1, 32'h0,        32'h02000000, 1'b0}, // R9 tick stopped
        {1'b1, 1'b0, 32'h0,        32'h00000003, 1'b0}, // R8 R7 reload
        {1'b1, 1'b0, 32'h01000100, 32'h01000100, 1'b0}, // R2 load 1:00
        {1'b0, 1'b1, 32'h0,        32'h01000059, 1'b0}, // R3 minute borrow
        {1'b1, 1'b0, 32'h0,        32'h00000059, 1'b0}, // R4 pause
        {1'b0, 1'b1, 32'h0,        32'h00000059, 1'b0}, // R9 tick ignored
        {1'b1, 1'b0, 32'h0,        32'h00000059, 1'b0}, // R9 zero write no-op
        {1'b1, 1'b0, 32'h01000000, 32'h01000059, 1'b0}, // R5 resume
        {1'b1, 1'b1, 32'h00010000, 32'h00010000, 1'b0}, // R10 write wins
        {1'b1, 1'b0, 32'h01000000, 32'h01010000, 1'b0}, // R5 resume
        {1'b0, 1'b1, 32'h0,        32'h01005959, 1'b0}, // R3 hour borrow
        {1'b1, 1'b0, 32'hFD000000, 32'h01005959, 1'b0}, // R11 R5 upper bits ignored
        {1'b1, 1'b0, 32'h03000000, 32'h00000000, 1'b0}, // R11 zero load no run
        {1'b0, 1'b1, 32'h0,        32'h00000000, 1'b0}, // R9
        {1'b1, 1'b0, 32'h01000000, 32'h00000000, 1'b0}, // R5 resume at zero
        {1'b1, 1'b0, 32'h0,        32'h00010000, 1'b0}  // R8 last start kept
    };

    task automatic step(input logic we, input logic tk, input logic [31:0] d);
        @(negedge clk);
        wr_en = we; tick = tk; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
    endtask

    task automatic check(input string req, input logic [31:0] exp_rd, input logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][66], VEC[i][65], VEC[i][64:33]);
            check($sformatf("vector %0d (R1-tagged table)", i), VEC[i][32:1], VEC[i][0]);
        end
        // R7: trigger cleared by a resume write at zero
        step(1'b1, 1'b0, 32'h01000001);
        step(1'b0, 1'b1, 32'h0);
        check("R6 expire 1s", 32'h02000000, 1'b1);
        step(1'b1, 1'b0, 32'h01000000);
        check("R7 resume clears trigger", 32'h00000000, 1'b0);
        // R7: trigger cleared by a load without run
        step(1'b1, 1'b0, 32'h01000001);
        step(1'b0, 1'b1, 32'h0);
        step(1'b1, 1'b0, 32'h00000010);
        check("R7 load clears trigger", 32'h00000010, 1'b0);
        // R1: reset mid-run returns to zero
        step(1'b1, 1'b0, 32'h01123456);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 32'h0, 1'b0);
        rst_n = 1'b1;
        // R8: reset clears saved start
        step(1'b1, 1'b0, 32'h0);
        check("R8 reload after reset", 32'h0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: expected run to finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule